// File: doc/BRIEF.md
# Slave-Port Round-Robin Arbiter with Slot Limit

This block decides which of several bus masters owns one slave port of a multi-master bus matrix. Each master presents a transfer-valid flag, an address and a burst-last flag. A per-master address decoder first decides whether the address targets this slave. Only masters whose address hits this slave compete. Among those, the grant rotates in round-robin order and is handed over only at a transfer boundary. A boundary is the end of a burst, an idle slave, or the expiry of the programmed slot cycle limit while another master is waiting.

A two-bit policy input selects what happens when nobody requests. The slave can be left ungranted, so each new access waits one arbitration cycle. The last owner can keep the grant, so its next access starts at once. A configured master can be parked on the port instead. The grant is registered and is presented both as a one-hot vector and as an index with a valid flag. A beat completes in every cycle where the granted master has its valid flag high and its address hits this slave.

Top module: `bus_slot_arbiter`

## Requirements
- R1: A master's region is the top four bits of its address (for the default 10 slaves). Region equal to SLAVE_ID (default 3) makes a request here. Region 10 or above raises that master's `dec_err_o` bit in the same cycle while it is valid. In that case no request is made, and a master with a bad address is never granted.
- R2: `gnt_o` has at most one bit set. When `gnt_vld_o` is 1, `gnt_o` has exactly the bit `gnt_idx_o`. When `gnt_vld_o` is 0, `gnt_o` is zero. After reset there is no grant and the index is 0.
- R3: At each boundary the new owner is the first requester found when scanning upward, wrapping around, from the master after the one last picked by round robin.
- R4: With `cfg_mode_i`=0, an idle slave has no grant. A request in cycle t is granted from cycle t+1.
- R5: With `cfg_mode_i`=1, the last owner keeps the grant while no one requests. Its new request completes a beat in the same cycle.
- R6: With `cfg_mode_i`=2, an idle slave is granted to `cfg_fixed_i` one cycle later. `cfg_mode_i`=3 behaves as mode 0.
- R7: While the owner completes beats with last=0, the grant does not change unless R8 applies.
- R8: With a limit L≠0, the L-th beat of one tenure moves the grant to another master in the next cycle, provided another master is requesting. With no other requester, the owner keeps the grant.
- R9: A limit of 0 never breaks a burst.
- R10: A master whose beat carries last=1 is not considered at that boundary. Other requesters win, or the idle policy applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mst_valid_i | input | NUM_MST | Per-master transfer valid |
| mst_last_i | input | NUM_MST | Per-master burst-last flag for the current beat |
| mst_addr_i | input | NUM_MST*ADDR_W | Per-master addresses, master m at bits [m*ADDR_W +: ADDR_W] |
| cfg_mode_i | input | 2 | Idle policy: 0 none, 1 keep last, 2 fixed, 3 as 0 |
| cfg_fixed_i | input | IDX_W | Master parked on the port in mode 2 |
| cfg_slot_lim_i | input | CNT_W | Beats per tenure before a forced handover; 0 disables |
| gnt_o | output | NUM_MST | One-hot grant |
| gnt_idx_o | output | IDX_W | Index of granted master |
| gnt_vld_o | output | 1 | A master holds the grant |
| dec_err_o | output | NUM_MST | Per-master address decode error |

## Verification
The bench drives several masters at once and follows the round-robin order across wrap-around. A pointer that fails to advance would starve a master or repeat one. Slot expiry is tested both with a competitor waiting and with no competitor. A wrong counter would either break early, never break, or hand the port to nobody. The bench also checks that a burst-last beat does not re-grant its own master. It probes each idle policy, including the spare mode code. It also checks that an undecodable address flags an error and is never granted. A decoder that leaked that request would grant it.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
    typedef enum logic [1:0] {
        IDLE_NONE  = 2'd0,
        IDLE_LAST  = 2'd1,
        IDLE_FIXED = 2'd2,
        IDLE_SPARE = 2'd3
    } idle_mode_e;
endpackage

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder #(
    parameter int ADDR_W   = 16,
    parameter int NUM_SLV  = 10,
    parameter int SLAVE_ID = 3
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic              err_o
);
    localparam int SEL_W = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1;

    logic [SEL_W-1:0] region;

    always_comb begin
        region = addr_i[ADDR_W-1 -: SEL_W];
        hit_o  = valid_i && (int'(region) == SLAVE_ID);
        err_o  = valid_i && (int'(region) >= NUM_SLV);
    end
endmodule

// File: rtl/bus_rr_picker.sv
module bus_rr_picker #(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input  logic [N-1:0]  cand_i,
    input  logic [IW-1:0] ptr_i,
    output logic          found_o,
    output logic [IW-1:0] pick_o
);
    always_comb begin
        found_o = 1'b0;
        pick_o  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            int j;
            j = int'(ptr_i) + i;
            if (j >= N) j = j - N;
            if (cand_i[j]) begin
                found_o = 1'b1;
                pick_o  = IW'(j);
            end
        end
    end
endmodule

// File: rtl/bus_slot_timer.sv
module bus_slot_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   cnt_next;

    always_comb begin
        cnt_next = {1'b0, cnt_q} + 1'b1;
        expire_o = (lim_i != '0) && inc_i && (cnt_next >= {1'b0, lim_i});
        if (clr_i)
            cnt_d = '0;
        else if (inc_i && !cnt_next[CNT_W])
            cnt_d = cnt_next[CNT_W-1:0];
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
    import bus_arb_pkg::*;
#(
    parameter int NUM_MST  = 7,
    parameter int NUM_SLV  = 10,
    parameter int SLAVE_ID = 3,
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 8,
    localparam int IDX_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_MST-1:0]        mst_valid_i,
    input  logic [NUM_MST-1:0]        mst_last_i,
    input  logic [NUM_MST*ADDR_W-1:0] mst_addr_i,
    input  logic [1:0]                cfg_mode_i,
    input  logic [IDX_W-1:0]          cfg_fixed_i,
    input  logic [CNT_W-1:0]          cfg_slot_lim_i,
    output logic [NUM_MST-1:0]        gnt_o,
    output logic [IDX_W-1:0]          gnt_idx_o,
    output logic                      gnt_vld_o,
    output logic [NUM_MST-1:0]        dec_err_o
);
    typedef struct packed {
        logic             owned;
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_MST-1:0] req;
    logic [NUM_MST-1:0] owner_oh;
    logic [NUM_MST-1:0] cand;
    logic               beat, cont, others, expire, slot_hit, rearb;
    logic               found;
    logic [IDX_W-1:0]   pick;
    logic               mode_none, fixed_ok;
    idle_mode_e         mode;

    for (genvar m = 0; m < NUM_MST; m++) begin : g_dec
        bus_addr_decoder #(
            .ADDR_W  (ADDR_W),
            .NUM_SLV (NUM_SLV),
            .SLAVE_ID(SLAVE_ID)
        ) dec_i (
            .valid_i(mst_valid_i[m]),
            .addr_i (mst_addr_i[m*ADDR_W +: ADDR_W]),
            .hit_o  (req[m]),
            .err_o  (dec_err_o[m])
        );
    end

    always_comb begin
        mode      = idle_mode_e'(cfg_mode_i);
        mode_none = (mode == IDLE_NONE) || (mode == IDLE_SPARE);
        fixed_ok  = int'(cfg_fixed_i) < NUM_MST;
        owner_oh  = st_q.owned ? (NUM_MST'(1) << st_q.owner) : '0;
        beat      = st_q.owned && req[st_q.owner];
        cont      = beat && !mst_last_i[st_q.owner];
        others    = |(req & ~owner_oh);
        slot_hit  = expire && others;
        rearb     = !cont || slot_hit;
        cand      = beat ? (req & ~owner_oh) : req;
    end

    bus_rr_picker #(.N(NUM_MST), .IW(IDX_W)) pick_i (
        .cand_i (cand),
        .ptr_i  (st_q.ptr),
        .found_o(found),
        .pick_o (pick)
    );

    bus_slot_timer #(.CNT_W(CNT_W)) slot_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (rearb),
        .inc_i   (beat),
        .lim_i   (cfg_slot_lim_i),
        .expire_o(expire)
    );

    always_comb begin
        st_d = st_q;
        if (rearb) begin
            if (found) begin
                st_d.owned = 1'b1;
                st_d.owner = pick;
                st_d.ptr   = (int'(pick) == NUM_MST - 1) ? '0 : pick + 1'b1;
            end else if (mode == IDLE_FIXED && fixed_ok) begin
                st_d.owned = 1'b1;
                st_d.owner = cfg_fixed_i;
            end else if (mode == IDLE_LAST) begin
                st_d.owned = st_q.owned;
            end else begin
                st_d.owned = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign gnt_o     = owner_oh;
    assign gnt_idx_o = st_q.owner;
    assign gnt_vld_o = st_q.owned;

    p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));
    p_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_vld_o |-> gnt_o[gnt_idx_o]);
    p_no_err_beat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beat |-> !dec_err_o[gnt_idx_o]);
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cont && !slot_hit) |=> (gnt_vld_o && gnt_idx_o == $past(gnt_idx_o)));
    p_break_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_hit |=> (gnt_vld_o && gnt_idx_o != $past(gnt_idx_o)));
    p_lim_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_slot_lim_i == '0) |-> !slot_hit);
    p_idle_none_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rearb && !found && mode_none) |=> !gnt_vld_o);
    p_idle_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rearb && !found && mode == IDLE_FIXED && fixed_ok)
        |=> (gnt_vld_o && gnt_idx_o == $past(cfg_fixed_i)));
endmodule

// File: tb/bus_slot_arbiter_tb.sv
module bus_slot_arbiter_tb_top;
    localparam int NM = 7;
    localparam int AW = 16;
    localparam int IW = 3;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] valid = '0;
    logic [NM-1:0] last = '0;
    logic [AW-1:0] addr [NM];
    logic [NM*AW-1:0] addr_flat;
    logic [1:0]    mode = 2'd0;
    logic [IW-1:0] fixed_m = '0;
    logic [CW-1:0] lim = '0;
    logic [NM-1:0] gnt;
    logic [IW-1:0] gidx;
    logic          gvld;
    logic [NM-1:0] derr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always_comb
        for (int m = 0; m < NM; m++) addr_flat[m*AW +: AW] = addr[m];

    bus_slot_arbiter dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mst_valid_i(valid), .mst_last_i(last),
        .mst_addr_i(addr_flat), .cfg_mode_i(mode), .cfg_fixed_i(fixed_m),
        .cfg_slot_lim_i(lim), .gnt_o(gnt), .gnt_idx_o(gidx), .gnt_vld_o(gvld),
        .dec_err_o(derr)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_gnt(input bit ev, input int ei, input string tag);
        logic [NM-1:0] eoh;
        eoh = ev ? (NM'(1) << ei) : '0;
        n_chk++;
        if (gvld !== ev || gnt !== eoh || (ev && gidx !== IW'(ei))) begin
            n_bad++;
            $display("FAIL %s: gnt=%b idx=%0d vld=%b expected gnt=%b idx=%0d vld=%b",
                     tag, gnt, gidx, gvld, eoh, ei, ev);
        end
    endtask

    task automatic chk_err(input logic [NM-1:0] e, input string tag);
        n_chk++;
        if (derr !== e) begin
            n_bad++;
            $display("FAIL %s: dec_err=%b expected %b", tag, derr, e);
        end
    endtask

    task automatic idle_all();
        valid = '0; last = '0;
        step();
    endtask

    task automatic t_reset();
        chk_gnt(1'b0, 0, "R2 reset");
        n_chk++;
        if (gidx !== '0) begin
            n_bad++;
            $display("FAIL R2 reset idx: %0d expected 0", gidx);
        end
        chk_err('0, "R1 reset");
    endtask

    task automatic t_decode();
        mode = 2'd0;
        addr[2] = 16'hF000; valid[2] = 1'b1; last[2] = 1'b1;
        #1 chk_err(7'b0000100, "R1 bad region flags");
        step();
        chk_gnt(1'b0, 0, "R1 bad region not granted");
        addr[2] = 16'hA123;
        #1 chk_err(7'b0000100, "R1 region 10 flags");
        addr[2] = 16'h5000;
        #1 chk_err('0, "R1 other slave no error");
        step();
        chk_gnt(1'b0, 0, "R1 other slave not granted");
        idle_all();
    endtask

    task automatic t_none();
        mode = 2'd0;
        addr[1] = 16'h3010; valid[1] = 1'b1; last[1] = 1'b1;
        #1 chk_gnt(1'b0, 0, "R4 no grant before edge");
        step();
        chk_gnt(1'b1, 1, "R4 grant one cycle later");
        step();
        valid[1] = 1'b0;
        chk_gnt(1'b0, 0, "R10 last beat not regranted, R4 idle empty");
        idle_all();
    endtask

    task automatic t_last();
        mode = 2'd1;
        addr[4] = 16'h3400; valid[4] = 1'b1; last[4] = 1'b1;
        step();
        chk_gnt(1'b1, 4, "R5 first grant");
        step();
        valid[4] = 1'b0;
        chk_gnt(1'b1, 4, "R5 kept after last beat");
        step(); step(); step();
        chk_gnt(1'b1, 4, "R5 kept while idle");
        valid[4] = 1'b1;
        #1 chk_gnt(1'b1, 4, "R5 beat without arbitration");
        step();
        valid[4] = 1'b0;
        idle_all();
    endtask

    task automatic t_fixed();
        mode = 2'd2; fixed_m = 3'd5;
        step();
        chk_gnt(1'b1, 5, "R6 parked on fixed master");
        fixed_m = 3'd6;
        step();
        chk_gnt(1'b1, 6, "R6 follows fixed index");
        mode = 2'd3;
        step();
        chk_gnt(1'b0, 0, "R6 spare mode acts as none");
        mode = 2'd0;
    endtask

    task automatic t_rr();
        int prev;
        int set [3] = '{0, 2, 5};
        mode = 2'd0; lim = '0;
        foreach (set[k]) begin
            addr[set[k]] = 16'h3000 + 16'(k);
            valid[set[k]] = 1'b1; last[set[k]] = 1'b1;
        end
        step();
        prev = int'(gidx);
        n_chk++;
        if (!gvld || !(prev == 0 || prev == 2 || prev == 5)) begin
            n_bad++;
            $display("FAIL R3 first grant: idx=%0d vld=%b expected one of 0,2,5", gidx, gvld);
        end
        for (int s = 0; s < 6; s++) begin
            int exp;
            exp = (prev == 0) ? 2 : (prev == 2) ? 5 : 0;
            step();
            chk_gnt(1'b1, exp, "R3 rotation");
            prev = exp;
        end
        idle_all();
        chk_gnt(1'b0, 0, "R4 empty after rotation");
    endtask

    task automatic t_burst_hold();
        mode = 2'd0; lim = '0;
        addr[1] = 16'h3100; valid[1] = 1'b1; last[1] = 1'b0;
        step();
        chk_gnt(1'b1, 1, "R7 burst start");
        addr[6] = 16'h3600; valid[6] = 1'b1; last[6] = 1'b1;
        for (int s = 0; s < 10; s++) begin
            step();
            chk_gnt(1'b1, 1, "R7 R9 held mid burst");
        end
        last[1] = 1'b1;
        step();
        valid[1] = 1'b0; last[1] = 1'b0;
        chk_gnt(1'b1, 6, "R10 handover at burst end");
        step();
        valid[6] = 1'b0;
        chk_gnt(1'b0, 0, "R4 empty after single beat");
        idle_all();
    endtask

    task automatic t_slot();
        mode = 2'd0; lim = 8'd3;
        addr[0] = 16'h3000; valid[0] = 1'b1; last[0] = 1'b0;
        step();
        chk_gnt(1'b1, 0, "R8 tenure start");
        addr[3] = 16'h3300; valid[3] = 1'b1; last[3] = 1'b1;
        step(); chk_gnt(1'b1, 0, "R8 beat 1");
        step(); chk_gnt(1'b1, 0, "R8 beat 2");
        step(); chk_gnt(1'b1, 3, "R8 break after limit");
        step(); chk_gnt(1'b1, 0, "R10 back to waiting burst");
        step(); chk_gnt(1'b1, 0, "R8 count restarted");
        valid[3] = 1'b0;
        for (int s = 0; s < 5; s++) begin
            step();
            chk_gnt(1'b1, 0, "R8 no break without competitor");
        end
        lim = '0;
        idle_all();
    endtask

    initial begin
        for (int m = 0; m < NM; m++) addr[m] = 16'h5000;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_decode();
        t_none();
        t_last();
        t_fixed();
        t_rr();
        t_burst_hold();
        t_slot();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule